// File: doc/BRIEF.md
# Piece count and location tracker

This block keeps a running material picture for a chess position evaluator. Twelve trackers exist, one for each combination of colour and piece kind. Each tracker holds how many pieces of its kind are on the board. It also holds the exclusive-OR of the square numbers of those pieces. Pieces are announced one at a time through an add strobe and a remove strobe. Each strobe carries a 4-bit piece code and a 6-bit square. A move is a remove and an add in the same cycle, so no full board scan is ever needed.

The XOR register costs almost nothing, yet it gives the exact square of a piece kind when a single piece of that kind remains. This is typically the case for a king, a lone queen or a last rook. The counts also form a compact game-phase index, and that index reads a small table. Each table entry returns a signed material correction plus two scale factors. One factor weights king safety. The other scales the pawn-structure and passed-pawn terms. The entries are loaded through a separate write port by whatever holds the tuning weights.

Top module: `mat_tracker`

## Requirements
- R1: While reset is asserted, every count, every location, every location-valid flag, the error flag and all table outputs read zero.
- R2: The piece code is 4 bits. Bit 3 is the colour (0 white, 1 black) and bits 2:0 are the kind: 0 pawn, 1 knight, 2 bishop, 3 rook, 4 queen, 5 king. The code selects tracker colour*6+kind, and tracker i occupies `cnt_o[i*CNT_W +: CNT_W]` and `loc_o[i*6 +: 6]`. An accepted add raises that count by one and an accepted remove lowers it by one. The new value is visible after the clock edge that samples the strobe.
- R3: Every accepted add or remove XORs its square into the location register of the selected tracker.
- R4: `loc_vld_o[i]` is high exactly when count i equals one; `loc_o` for that tracker then shows the register, and otherwise reads zero.
- R5: A count stops at 2^CNT_W-1. An add that arrives at that value is dropped, and both the count and the location stay unchanged.
- R6: A remove aimed at a tracker whose count is zero is dropped, and its count and location stay unchanged. `rem_err_o` is high for the one cycle after it and low after any cycle without such a remove.
- R7: A strobe whose kind field is 6 or 7 changes no tracker.
- R8: An add and a remove that hit the same tracker in the same cycle leave its count unchanged and XOR both squares into its location.
- R9: The 8-bit phase index is built from the counts. Bit 7 is set when the white queen count is nonzero and bit 6 when the black queen count is nonzero. Bit 5 is set when the white rook count is nonzero and bit 4 when the black rook count is nonzero. Bits 3:2 hold white knights plus bishops, clipped at 3, and bits 1:0 hold the same sum for black.
- R10: One clock edge after the counts change, the table outputs show the entry at the new phase index. An entry is laid out as bonus in bits 17:8, king-safety factor in bits 7:4 and pawn scale in bits 3:0.
- R11: A table write stores its entry at the write address. A read of that address in the same cycle returns the old entry, and the new entry appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| add_vld | input | 1 | Add strobe |
| add_pc | input | 4 | Piece code of added piece |
| add_sq | input | 6 | Square of added piece |
| rem_vld | input | 1 | Remove strobe |
| rem_pc | input | 4 | Piece code of removed piece |
| rem_sq | input | 6 | Square of removed piece |
| tbl_we | input | 1 | Phase table write enable |
| tbl_waddr | input | 8 | Phase table write address |
| tbl_wdata | input | BONUS_W+2*MULT_W | Phase table entry |
| cnt_o | output | 12*CNT_W | Per-tracker counts |
| loc_o | output | 72 | Per-tracker unique square, zero unless valid |
| loc_vld_o | output | 12 | Per-tracker unique-square flag |
| bonus_o | output | BONUS_W | Signed material correction |
| ksafe_o | output | MULT_W | King-safety factor |
| pscale_o | output | MULT_W | Pawn-structure scale |
| rem_err_o | output | 1 | Remove of an absent piece seen last cycle |

## Verification
The bench removes one of two pawns and expects the survivor's square to appear. A design that only ORed squares, or did not fold removes into the register, would show a wrong square there. The bench pushes a sixteenth pawn onto a full tracker. A count that wrapped to zero, or a location that still took the dropped square, would then be visible. It also removes a queen that is not on the board, expecting no underflow and a single error pulse. It moves a rook in one cycle; a design that let one strobe win would change the count. It loads four minor pieces to check clipping in the phase index, and rewrites the entry being read to expose an output that returns the new data too early.

// File: rtl/mat_pkg.sv
package mat_pkg;
  localparam int unsigned NTYPE  = 6;
  localparam int unsigned NCOL   = 2;
  localparam int unsigned NSLOT  = NTYPE * NCOL;
  localparam int unsigned SQ_W   = 6;
  localparam int unsigned SLOT_W = $clog2(NSLOT);
  localparam int unsigned PH_AW  = 8;

  typedef enum logic [2:0] {
    PK_PAWN   = 3'd0,
    PK_KNIGHT = 3'd1,
    PK_BISHOP = 3'd2,
    PK_ROOK   = 3'd3,
    PK_QUEEN  = 3'd4,
    PK_KING   = 3'd5
  } pkind_e;

  function automatic logic kind_ok(input logic [3:0] pc);
    return pc[2:0] <= 3'(PK_KING);
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [3:0] pc);
    return pc[3] ? (SLOT_W'(pc[2:0]) + SLOT_W'(NTYPE)) : SLOT_W'(pc[2:0]);
  endfunction
endpackage

// File: rtl/mat_slot.sv
module mat_slot #(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned SQ_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_hit,
  input  logic [SQ_W-1:0]  add_sq,
  input  logic             rem_hit,
  input  logic [SQ_W-1:0]  rem_sq,
  output logic [CNT_W-1:0] cnt,
  output logic [SQ_W-1:0]  loc,
  output logic             loc_vld,
  output logic             err
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SQ_W-1:0]  loc_q, loc_d;
  logic             err_q, err_d;
  logic             upd_en;

  assign upd_en = add_hit | rem_hit;

  always_comb begin
    cnt_d = cnt_q;
    loc_d = loc_q;
    err_d = 1'b0;
    unique case ({add_hit, rem_hit})
      2'b11: loc_d = loc_q ^ add_sq ^ rem_sq;
      2'b10: begin
        if (cnt_q != CNT_MAX) begin
          cnt_d = cnt_q + CNT_W'(1);
          loc_d = loc_q ^ add_sq;
        end
      end
      2'b01: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - CNT_W'(1);
          loc_d = loc_q ^ rem_sq;
        end else begin
          err_d = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      loc_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
      if (upd_en) begin
        cnt_q <= cnt_d;
        loc_q <= loc_d;
      end
    end
  end

  assign cnt     = cnt_q;
  assign loc_vld = (cnt_q == CNT_W'(1));
  assign loc     = loc_vld ? loc_q : '0;
  assign err     = err_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + CNT_W'(1)) ||
    (cnt_q == $past(cnt_q) - CNT_W'(1)));                               // R2
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && add_hit && !rem_hit) |=> (cnt_q == CNT_MAX && $stable(loc_q))); // R5
  AST_EMPTY_REMOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && rem_hit && !add_hit) |=> (err && cnt_q == '0));    // R6
  AST_PAIR_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (add_hit && rem_hit) |=> $stable(cnt_q));                           // R8
endmodule

// File: rtl/mat_phase_addr.sv
module mat_phase_addr
  import mat_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [NSLOT*CNT_W-1:0] cnt_flat,
  output logic [PH_AW-1:0]       addr
);
  logic [NCOL-1:0] q_any;
  logic [NCOL-1:0] r_any;
  logic [1:0]      m_clip [NCOL];

  for (genvar c = 0; c < NCOL; c++) begin : g_col
    localparam int unsigned BASE = c * NTYPE;
    logic [CNT_W-1:0] n_kn, n_bi, n_q, n_r;
    logic [CNT_W:0]   m_sum;
    assign n_kn  = cnt_flat[(BASE + int'(PK_KNIGHT))*CNT_W +: CNT_W];
    assign n_bi  = cnt_flat[(BASE + int'(PK_BISHOP))*CNT_W +: CNT_W];
    assign n_q   = cnt_flat[(BASE + int'(PK_QUEEN))*CNT_W +: CNT_W];
    assign n_r   = cnt_flat[(BASE + int'(PK_ROOK))*CNT_W +: CNT_W];
    assign m_sum = {1'b0, n_kn} + {1'b0, n_bi};
    assign q_any[c]  = (n_q != '0);
    assign r_any[c]  = (n_r != '0);
    assign m_clip[c] = (m_sum > (CNT_W+1)'(3)) ? 2'd3 : m_sum[1:0];
  end

  assign addr = {q_any[0], q_any[1], r_any[0], r_any[1], m_clip[0], m_clip[1]};
endmodule

// File: rtl/mat_phase_tbl.sv
module mat_phase_tbl #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= mem[raddr];
  end

  assign rdata = rd_q;

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    we ##1 (raddr == $past(waddr)) |=> (rdata == $past(wdata, 2)));    // R11
endmodule

// File: rtl/mat_tracker.sv
module mat_tracker
  import mat_pkg::*;
#(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned BONUS_W = 10,
  parameter int unsigned MULT_W  = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        add_vld,
  input  logic [3:0]                  add_pc,
  input  logic [5:0]                  add_sq,
  input  logic                        rem_vld,
  input  logic [3:0]                  rem_pc,
  input  logic [5:0]                  rem_sq,
  input  logic                        tbl_we,
  input  logic [7:0]                  tbl_waddr,
  input  logic [BONUS_W+2*MULT_W-1:0] tbl_wdata,
  output logic [12*CNT_W-1:0]         cnt_o,
  output logic [71:0]                 loc_o,
  output logic [11:0]                 loc_vld_o,
  output logic [BONUS_W-1:0]          bonus_o,
  output logic [MULT_W-1:0]           ksafe_o,
  output logic [MULT_W-1:0]           pscale_o,
  output logic                        rem_err_o
);
  localparam int unsigned TBL_W = BONUS_W + 2*MULT_W;

  logic              rst_meta, rst_i;
  logic              add_ok, rem_ok;
  logic [SLOT_W-1:0] add_idx, rem_idx;
  logic [NSLOT-1:0]  slot_err;
  logic [PH_AW-1:0]  ph_addr;
  logic [TBL_W-1:0]  tbl_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_i    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_i    <= rst_meta;
    end
  end

  assign add_ok  = add_vld && kind_ok(add_pc);
  assign rem_ok  = rem_vld && kind_ok(rem_pc);
  assign add_idx = slot_of(add_pc);
  assign rem_idx = slot_of(rem_pc);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    mat_slot #(.CNT_W(CNT_W), .SQ_W(SQ_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_i),
      .add_hit (add_ok && (add_idx == SLOT_W'(s))),
      .add_sq  (add_sq),
      .rem_hit (rem_ok && (rem_idx == SLOT_W'(s))),
      .rem_sq  (rem_sq),
      .cnt     (cnt_o[s*CNT_W +: CNT_W]),
      .loc     (loc_o[s*SQ_W +: SQ_W]),
      .loc_vld (loc_vld_o[s]),
      .err     (slot_err[s])
    );
  end

  assign rem_err_o = |slot_err;

  mat_phase_addr #(.CNT_W(CNT_W)) u_paddr (
    .cnt_flat (cnt_o),
    .addr     (ph_addr)
  );

  mat_phase_tbl #(.AW(PH_AW), .DW(TBL_W)) u_tbl (
    .clk   (clk),
    .rst_n (rst_i),
    .we    (tbl_we),
    .waddr (tbl_waddr),
    .wdata (tbl_wdata),
    .raddr (ph_addr),
    .rdata (tbl_rd)
  );

  assign bonus_o  = tbl_rd[TBL_W-1 -: BONUS_W];
  assign ksafe_o  = tbl_rd[2*MULT_W-1 -: MULT_W];
  assign pscale_o = tbl_rd[MULT_W-1:0];

  AST_BAD_KIND_IGNORED: assert property (@(posedge clk) disable iff (!rst_i)
    (add_vld && !kind_ok(add_pc) && !rem_vld) |=> ($stable(cnt_o) && $stable(loc_o))); // R7
  AST_ERR_ONLY_ON_REMOVE: assert property (@(posedge clk) disable iff (!rst_i)
    !rem_vld |=> !rem_err_o);                                           // R6
endmodule

// File: tb/mat_tracker_tb.sv
module mat_tracker_tb;
  localparam int CW = 4;
  localparam int NS = 12;
  localparam int MAXC = (1 << CW) - 1;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n;
  logic         add_vld, rem_vld, tbl_we;
  logic [3:0]   add_pc, rem_pc;
  logic [5:0]   add_sq, rem_sq;
  logic [7:0]   tbl_waddr;
  logic [17:0]  tbl_wdata;
  logic [NS*CW-1:0] cnt_o;
  logic [71:0]  loc_o;
  logic [11:0]  loc_vld_o;
  logic [9:0]   bonus_o;
  logic [3:0]   ksafe_o, pscale_o;
  logic         rem_err_o;

  mat_tracker u_dut (
    .clk(clk), .rst_n(rst_n),
    .add_vld(add_vld), .add_pc(add_pc), .add_sq(add_sq),
    .rem_vld(rem_vld), .rem_pc(rem_pc), .rem_sq(rem_sq),
    .tbl_we(tbl_we), .tbl_waddr(tbl_waddr), .tbl_wdata(tbl_wdata),
    .cnt_o(cnt_o), .loc_o(loc_o), .loc_vld_o(loc_vld_o),
    .bonus_o(bonus_o), .ksafe_o(ksafe_o), .pscale_o(pscale_o),
    .rem_err_o(rem_err_o)
  );

  typedef struct {
    int    due;
    int    kind;
    int    idx;
    int    exp;
    string tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  int m_cnt [NS];
  int m_loc [NS];
  int m_tbl [256];

  function automatic void chk(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endfunction

  function automatic int got_of(int kind, int idx);
    case (kind)
      0: return int'(cnt_o[idx*CW +: CW]);
      1: return int'(loc_o[idx*6 +: 6]);
      2: return int'(loc_vld_o[idx]);
      3: return int'(rem_err_o);
      default: return int'({bonus_o, ksafe_o, pscale_o});
    endcase
  endfunction

  function automatic int paddr();
    int wm, bm;
    wm = m_cnt[1] + m_cnt[2];
    bm = m_cnt[7] + m_cnt[8];
    if (wm > 3) wm = 3;
    if (bm > 3) bm = 3;
    return (m_cnt[4] != 0 ? 128 : 0) + (m_cnt[10] != 0 ? 64 : 0) +
           (m_cnt[3] != 0 ? 32 : 0) + (m_cnt[9] != 0 ? 16 : 0) + wm*4 + bm;
  endfunction

  function automatic void push(int due, int kind, int idx, int exp, string tag);
    item_t it;
    it.due = due; it.kind = kind; it.idx = idx; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endfunction

  // monitor: compares every item whose cycle has come
  always @(posedge clk) begin
    cyc = cyc + 1;
    #3;
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        chk(q[i].tag, got_of(q[i].kind, q[i].idx), q[i].exp);
        q.delete(i);
      end
    end
  end

  // driver: one event per cycle, called at a falling edge
  task automatic ev(string tag, bit av, logic [3:0] apc, int asq,
                    bit rv, logic [3:0] rpc, int rsq);
    int ai, ri;
    bit e;
    add_vld = av; add_pc = apc; add_sq = 6'(asq);
    rem_vld = rv; rem_pc = rpc; rem_sq = 6'(rsq);
    ai = (av && apc[2:0] <= 3'd5) ? int'(apc[3]) * 6 + int'(apc[2:0]) : -1;
    ri = (rv && rpc[2:0] <= 3'd5) ? int'(rpc[3]) * 6 + int'(rpc[2:0]) : -1;
    e = 1'b0;
    for (int s = 0; s < NS; s++) begin
      if (ai == s && ri == s) begin
        m_loc[s] = m_loc[s] ^ asq ^ rsq;
      end else if (ai == s) begin
        if (m_cnt[s] != MAXC) begin m_cnt[s]++; m_loc[s] ^= asq; end
      end else if (ri == s) begin
        if (m_cnt[s] != 0) begin m_cnt[s]--; m_loc[s] ^= rsq; end
        else e = 1'b1;
      end
    end
    for (int s = 0; s < NS; s++) begin
      push(cyc + 1, 0, s, m_cnt[s], $sformatf("%s R2 cnt[%0d]", tag, s));
      push(cyc + 1, 1, s, (m_cnt[s] == 1) ? m_loc[s] : 0, $sformatf("%s R3 loc[%0d]", tag, s));
      push(cyc + 1, 2, s, (m_cnt[s] == 1) ? 1 : 0, $sformatf("%s R4 vld[%0d]", tag, s));
    end
    push(cyc + 1, 3, 0, int'(e), {tag, " R6 err"});
    push(cyc + 2, 4, 0, m_tbl[paddr()], {tag, " R10 table"});
    @(negedge clk);
    add_vld = 1'b0; rem_vld = 1'b0;
  endtask

  task automatic tw(string tag, int a, int d, bit check);
    int pa;
    pa = paddr();
    tbl_we = 1'b1; tbl_waddr = 8'(a); tbl_wdata = 18'(d);
    if (check) push(cyc + 1, 4, 0, m_tbl[pa], {tag, " R11 old entry"});
    m_tbl[a] = d;
    if (check) push(cyc + 2, 4, 0, m_tbl[pa], {tag, " R11 new entry"});
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  initial begin
    #(100000 * 10);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NS; s++) begin m_cnt[s] = 0; m_loc[s] = 0; end
    rst_n = 1'b0;
    add_vld = 1'b0; add_pc = '0; add_sq = '0;
    rem_vld = 1'b0; rem_pc = '0; rem_sq = '0;
    tbl_we = 1'b0; tbl_waddr = '0; tbl_wdata = '0;
    #32;
    // R1 reset state
    chk("R1 counts", int'(cnt_o != '0), 0);
    chk("R1 locations", int'(loc_o != '0), 0);
    chk("R1 valid flags", int'(loc_vld_o), 0);
    chk("R1 table out", int'({bonus_o, ksafe_o, pscale_o}), 0);
    chk("R1 error flag", int'(rem_err_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int a = 0; a < 256; a++) tw("fill", a, (a * 1237 + 91) % 262144, 1'b0);
    repeat (2) @(negedge clk);

    ev("R2 white king", 1, 4'b0101, 4, 0, 4'b0, 0);
    ev("R2 black king", 1, 4'b1101, 60, 0, 4'b0, 0);
    ev("R4 pawn one", 1, 4'b0000, 8, 0, 4'b0, 0);
    ev("R4 pawn two", 1, 4'b0000, 9, 0, 4'b0, 0);
    ev("R3 pawn removed", 0, 4'b0, 0, 1, 4'b0000, 8);
    ev("R2 white rook", 1, 4'b0011, 0, 0, 4'b0, 0);
    ev("R8 rook move", 1, 4'b0011, 7, 1, 4'b0011, 0);
    ev("R3 cross move", 1, 4'b0101, 5, 1, 4'b0000, 9);
    ev("R9 white queen", 1, 4'b0100, 3, 0, 4'b0, 0);
    ev("R9 black rook", 1, 4'b1011, 56, 0, 4'b0, 0);
    ev("R9 knight a", 1, 4'b0001, 1, 0, 4'b0, 0);
    ev("R9 bishop a", 1, 4'b0010, 2, 0, 4'b0, 0);
    ev("R9 knight b", 1, 4'b0001, 6, 0, 4'b0, 0);
    ev("R9 bishop b clip", 1, 4'b0010, 13, 0, 4'b0, 0);
    ev("R9 black knight", 1, 4'b1001, 57, 0, 4'b0, 0);
    ev("R9 black queen", 1, 4'b1100, 59, 0, 4'b0, 0);
    ev("R6 second black queen gone", 0, 4'b0, 0, 1, 4'b1100, 59);
    ev("R6 absent black queen", 0, 4'b0, 0, 1, 4'b1100, 59);
    ev("R6 error clears", 0, 4'b0, 0, 0, 4'b0, 0);
    ev("R7 bad kind add", 1, 4'b0110, 20, 0, 4'b0, 0);
    ev("R7 bad kind both", 1, 4'b1111, 21, 1, 4'b0111, 3);
    for (int i = 0; i < 16; i++) ev("R5 pawn fill", 1, 4'b1000, 40 + i, 0, 4'b0, 0);
    ev("R5 after cap remove", 0, 4'b0, 0, 1, 4'b1000, 40);
    ev("R10 queen off", 0, 4'b0, 0, 1, 4'b0100, 3);
    tw("R11 same address", paddr(), 18'h15A5A, 1'b1);
    repeat (3) @(negedge clk);
    ev("R10 rook off", 0, 4'b0, 0, 1, 4'b1011, 56);
    repeat (4) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule